// File: doc/BRIEF.md
# Host In-Order Request Queue

This block tracks pipelined address requests from a host bus while they wait for completion. Each accepted request goes into a circular in-order queue of up to twelve entries. An entry holds the 64-byte line address, a read/write flag, a target-interface code and a deferred flag. The response side always sees the oldest entry at the head, and it retires entries one at a time, strictly in the order they were accepted.

Some requests are answered with a defer response and finish later. These need a defer slot, which is reserved when the request is accepted. At most two slots exist, and no two busy slots may carry the same target. When a deferred entry retires from the head, its slot moves to waiting for the deferred reply. A reply-done strobe for that target then frees the slot. The block raises a stall output in the same cycle when the queue is full, or when a request that needs deferral cannot get a slot. A stalled request is not stored.

Each defer slot runs its own state machine with three states: SLOT_FREE, SLOT_QUEUED and SLOT_AWAIT. It moves FREE→QUEUED on allocation, QUEUED→AWAIT when the deferred head of its target retires, and AWAIT→FREE on a reply-done for its target. The queue runs a state machine with RING_EMPTY, RING_PART and RING_FULL. It moves EMPTY→PART on a push, PART→EMPTY when the count reaches zero, PART→FULL when the count reaches the depth, and FULL→PART on a pop without a push.

Top module: `host_ioq`

## Requirements
- R1: After a synchronous active-high reset, head_valid is 0, q_count is 0, dfr_wait is 0, and req_stall is 0 even when req_defer is 1.
- R2: Entries leave the head in exactly the order they were accepted. Each carries the write flag, the target code and the deferred flag it was accepted with, and head_addr[31:6] equals req_addr[31:6] of that request.
- R3: The queue holds at most 12 entries and q_count reports how many it holds. With 12 held, req_stall is 1 and a request is not stored.
- R4: head_addr[5:0] is always 0, because entries are tracked per 64-byte line.
- R5: A request with req_defer=1 stalls when both defer slots are busy.
- R6: A request with req_defer=1 stalls when a busy slot already holds its target code. A request with req_defer=0 to that same target is accepted. Target codes are 0 DRAM, 1 AGP/PCI, 2 hub, 3 configuration.
- R7: dfr_wait[t] goes to 1 in the cycle after a deferred head entry with target t retires.
- R8: dfr_done with dfr_done_tgt=t frees the slot only when dfr_wait[t] is 1. dfr_wait[t] is then 0 in the next cycle, and a deferred request to t is accepted from that cycle on. A dfr_done for a target that is not waiting has no effect.
- R9: req_stall depends on the current cycle's inputs. An accepted request is visible at the head of an empty queue, and counted in q_count, in the next cycle.
- R10: A push and a pop in the same cycle leave q_count unchanged.
- R11: Reset asserted during operation discards every queued entry and every defer slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request offered |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt | input | 2 | Target code: 0 DRAM, 1 AGP/PCI, 2 hub, 3 configuration |
| req_defer | input | 1 | Request will be answered with a defer response |
| req_stall | output | 1 | Request cannot be accepted this cycle |
| rsp_ready | input | 1 | Retire the head entry this cycle |
| head_valid | output | 1 | Queue holds at least one entry |
| head_addr | output | 32 | Line address of the head entry, low 6 bits zero |
| head_write | output | 1 | Write flag of the head entry |
| head_tgt | output | 2 | Target code of the head entry |
| head_deferred | output | 1 | Head entry retires with a defer response |
| dfr_done | input | 1 | A deferred reply has completed |
| dfr_done_tgt | input | 2 | Target of the completed deferred reply |
| dfr_wait | output | 4 | Per target, a deferred reply is outstanding |
| q_count | output | 4 | Number of queued entries |

## Verification
req_stall is combinational, so the bench drives each cycle's inputs at the falling edge and samples req_stall one nanosecond later. The head fields, q_count and dfr_wait are registered. They reflect every accept, retire and reply-done from the previous rising edge. The bench compares them at the next falling edge against a model it has already advanced by one cycle. Checks for R7, R8, R9 and R10 therefore look exactly one cycle after the stimulus.

// File: rtl/hioq_pkg.sv
package hioq_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 64;
    localparam int LINE_LSB   = $clog2(LINE_BYTES);
    localparam int LINE_W     = ADDR_W - LINE_LSB;
    localparam int TGT_W      = 2;
    localparam int NUM_TGT    = 1 << TGT_W;

    typedef enum logic [TGT_W-1:0] {
        TGT_DRAM = 2'd0,
        TGT_GFX  = 2'd1,
        TGT_HUB  = 2'd2,
        TGT_CFG  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              wr;
        tgt_e              tgt;
        logic              dfr;
    } ent_t;

    typedef enum logic [1:0] {
        SLOT_FREE,
        SLOT_QUEUED,
        SLOT_AWAIT
    } slot_st_e;

    typedef enum logic [1:0] {
        RING_EMPTY,
        RING_PART,
        RING_FULL
    } ring_st_e;
endpackage

// File: rtl/hioq_ring.sv
module hioq_ring
    import hioq_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt, cnt_nx;
    ring_st_e      st, st_nx;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cnt_nx = cnt + CW'(push) - CW'(pop);
        st_nx  = st;
        unique case (st)
            RING_EMPTY: if (push) st_nx = (cnt_nx == CW'(DEPTH)) ? RING_FULL : RING_PART;
            RING_PART: begin
                if (cnt_nx == '0)                st_nx = RING_EMPTY;
                else if (cnt_nx == CW'(DEPTH))   st_nx = RING_FULL;
            end
            RING_FULL:  if (pop && !push) st_nx = RING_PART;
            default:    st_nx = RING_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RING_EMPTY;
            cnt    <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_comb begin
        full  = (st == RING_FULL);
        empty = (st == RING_EMPTY);
        dout  = mem[rd_ptr];
        count = cnt;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);                                           // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);                                           // R2
    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (rst)
        full |-> (cnt == CW'(DEPTH)));                             // R3
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (cnt == $past(cnt)));                    // R10
endmodule

// File: rtl/hioq_defer_slot.sv
module hioq_defer_slot
    import hioq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc,
    input  tgt_e alloc_tgt,
    input  logic ret_dfr,
    input  tgt_e ret_tgt,
    input  logic done,
    input  tgt_e done_tgt,
    output logic busy,
    output logic waiting,
    output tgt_e tgt_o
);
    slot_st_e st, st_nx;
    tgt_e     tgt_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            SLOT_FREE:   if (alloc) st_nx = SLOT_QUEUED;
            SLOT_QUEUED: if (ret_dfr && ret_tgt == tgt_q) st_nx = SLOT_AWAIT;
            SLOT_AWAIT:  if (done && done_tgt == tgt_q) st_nx = SLOT_FREE;
            default:     st_nx = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SLOT_FREE;
            tgt_q <= TGT_DRAM;
        end else begin
            st <= st_nx;
            if (alloc && st == SLOT_FREE) tgt_q <= alloc_tgt;
        end
    end

    always_comb begin
        busy    = (st != SLOT_FREE);
        waiting = (st == SLOT_AWAIT);
        tgt_o   = tgt_q;
    end

    AST_SLOT_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (st == SLOT_FREE));                              // R5
    AST_AWAIT_FROM_QUEUED: assert property (@(posedge clk) disable iff (rst)
        (st == SLOT_AWAIT && $past(st) != SLOT_AWAIT) |-> ($past(st) == SLOT_QUEUED)); // R7
    AST_FREE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (st == SLOT_AWAIT && !done) |=> (st == SLOT_AWAIT));       // R8
endmodule

// File: rtl/host_ioq.sv
module host_ioq
    import hioq_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int DFR_SLOTS = 2,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int SW       = (DFR_SLOTS > 1) ? $clog2(DFR_SLOTS) : 1,
    localparam int EW       = $bits(ent_t)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic [TGT_W-1:0]   req_tgt,
    input  logic               req_defer,
    output logic               req_stall,
    input  logic               rsp_ready,
    output logic               head_valid,
    output logic [ADDR_W-1:0]  head_addr,
    output logic               head_write,
    output logic [TGT_W-1:0]   head_tgt,
    output logic               head_deferred,
    input  logic               dfr_done,
    input  logic [TGT_W-1:0]   dfr_done_tgt,
    output logic [NUM_TGT-1:0] dfr_wait,
    output logic [CW-1:0]      q_count
);
    logic                 ring_full, ring_empty, push, pop, ret_dfr;
    logic [EW-1:0]        ring_dout;
    ent_t                 din_e, head_e;
    logic [DFR_SLOTS-1:0] slot_busy, slot_wait, slot_alloc;
    tgt_e                 slot_tgt [DFR_SLOTS];
    logic                 any_free, tgt_clash, dfr_block;
    logic [SW-1:0]        free_idx;

    always_comb begin
        din_e.line = req_addr[ADDR_W-1:LINE_LSB];
        din_e.wr   = req_write;
        din_e.tgt  = tgt_e'(req_tgt);
        din_e.dfr  = req_defer;
        head_e     = ent_t'(ring_dout);
    end

    hioq_ring #(.DEPTH(DEPTH), .W(EW)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (din_e),
        .pop   (pop),
        .dout  (ring_dout),
        .full  (ring_full),
        .empty (ring_empty),
        .count (q_count)
    );

    always_comb begin
        any_free  = 1'b0;
        free_idx  = '0;
        tgt_clash = 1'b0;
        for (int i = DFR_SLOTS - 1; i >= 0; i--) begin
            if (!slot_busy[i]) begin
                any_free = 1'b1;
                free_idx = SW'(i);
            end
        end
        for (int i = 0; i < DFR_SLOTS; i++) begin
            if (slot_busy[i] && slot_tgt[i] == tgt_e'(req_tgt)) tgt_clash = 1'b1;
        end
        dfr_block = !any_free || tgt_clash;
        req_stall = ring_full || (req_defer && dfr_block);
        push      = req_valid && !req_stall;
        pop       = rsp_ready && !ring_empty;
        ret_dfr   = pop && head_e.dfr;
    end

    for (genvar s = 0; s < DFR_SLOTS; s++) begin : g_slot
        assign slot_alloc[s] = push && req_defer && (free_idx == SW'(s));
        hioq_defer_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc     (slot_alloc[s]),
            .alloc_tgt (tgt_e'(req_tgt)),
            .ret_dfr   (ret_dfr),
            .ret_tgt   (head_e.tgt),
            .done      (dfr_done),
            .done_tgt  (tgt_e'(dfr_done_tgt)),
            .busy      (slot_busy[s]),
            .waiting   (slot_wait[s]),
            .tgt_o     (slot_tgt[s])
        );
    end

    logic [DFR_SLOTS-1:0] tgt_hold [NUM_TGT];

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        always_comb begin
            dfr_wait[t] = 1'b0;
            for (int i = 0; i < DFR_SLOTS; i++) begin
                tgt_hold[t][i] = slot_busy[i] && (slot_tgt[i] == tgt_e'(t));
                if (slot_wait[i] && slot_tgt[i] == tgt_e'(t)) dfr_wait[t] = 1'b1;
            end
        end

        AST_ONE_PER_TGT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(tgt_hold[t]));                                // R6
        AST_WAIT_AFTER_RETIRE: assert property (@(posedge clk) disable iff (rst)
            $rose(dfr_wait[t]) |-> ($past(ret_dfr) && $past(head_tgt) == TGT_W'(t))); // R7
    end

    always_comb begin
        head_valid    = !ring_empty;
        head_addr     = {head_e.line, {LINE_LSB{1'b0}}};
        head_write    = head_e.wr;
        head_tgt      = head_e.tgt;
        head_deferred = head_e.dfr;
    end

    AST_STALL_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_stall && !pop) |=> (q_count == $past(q_count)));  // R3
    AST_SLOT_CAP: assert property (@(posedge clk) disable iff (rst)
        (req_defer && !any_free) |-> req_stall);                   // R5
endmodule

// File: tb/host_ioq_bench.sv
`timescale 1ns/1ps
module host_ioq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_defer = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_tgt = '0, dfr_done_tgt = '0;
    logic        rsp_ready = 1'b0, dfr_done = 1'b0;
    logic        req_stall, head_valid, head_write, head_deferred;
    logic [31:0] head_addr;
    logic [1:0]  head_tgt;
    logic [3:0]  dfr_wait, q_count;

    int n_run = 0, n_fail = 0;
    bit fin = 0;

    // bench model
    int          mq_n;
    logic [25:0] mq_line [16];
    logic        mq_wr [16];
    logic [1:0]  mq_tgt [16];
    logic        mq_dfr [16];
    int          ms_st [2];
    logic [1:0]  ms_tgt [2];

    always #4 clk = ~clk;

    host_ioq u_host_ioq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_tgt(req_tgt), .req_defer(req_defer),
        .req_stall(req_stall), .rsp_ready(rsp_ready), .head_valid(head_valid),
        .head_addr(head_addr), .head_write(head_write), .head_tgt(head_tgt),
        .head_deferred(head_deferred), .dfr_done(dfr_done),
        .dfr_done_tgt(dfr_done_tgt), .dfr_wait(dfr_wait), .q_count(q_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_wait();
        logic [3:0] w = '0;
        for (int i = 0; i < 2; i++) if (ms_st[i] == 2) w[ms_tgt[i]] = 1'b1;
        return w;
    endfunction

    function automatic logic exp_stall(input logic d, input logic [1:0] t);
        logic anyfree = 1'b0, clash = 1'b0;
        for (int i = 0; i < 2; i++) begin
            if (ms_st[i] == 0) anyfree = 1'b1;
            else if (ms_tgt[i] == t) clash = 1'b1;
        end
        return (mq_n == 12) || (d && (!anyfree || clash));
    endfunction

    function automatic string stall_tag(input logic d, input logic [1:0] t);
        logic anyfree = 1'b0, clash = 1'b0;
        for (int i = 0; i < 2; i++) begin
            if (ms_st[i] == 0) anyfree = 1'b1;
            else if (ms_tgt[i] == t) clash = 1'b1;
        end
        if (mq_n == 12) return "R3 stall";
        if (d && !anyfree) return "R5 stall";
        if (d && clash) return "R6 stall";
        return "R9 stall";
    endfunction

    task automatic model_reset();
        mq_n = 0;
        for (int i = 0; i < 2; i++) begin ms_st[i] = 0; ms_tgt[i] = 0; end
    endtask

    task automatic cyc(input logic r, input logic v, input logic [31:0] a, input logic w,
                       input logic [1:0] t, input logic d, input logic rdy,
                       input logic dn, input logic [1:0] dt);
        logic st_e, acc, pp;
        int   o_st [2];
        @(negedge clk);
        rst = r; req_valid = v; req_addr = a; req_write = w; req_tgt = t;
        req_defer = d; rsp_ready = rdy; dfr_done = dn; dfr_done_tgt = dt;
        #1;
        if (!r) begin
            st_e = exp_stall(d, t);
            chk(stall_tag(d, t), {31'd0, req_stall}, {31'd0, st_e});
            chk("R3 count", {28'd0, q_count}, mq_n);
            chk("R2 head_valid", {31'd0, head_valid}, {31'd0, mq_n > 0});
            chk("R7 dfr_wait", {28'd0, dfr_wait}, {28'd0, exp_wait()});
            if (mq_n > 0) begin
                chk("R2 head line", {6'd0, head_addr[31:6]}, {6'd0, mq_line[0]});
                chk("R4 low bits", {26'd0, head_addr[5:0]}, 32'd0);
                chk("R2 head write", {31'd0, head_write}, {31'd0, mq_wr[0]});
                chk("R2 head tgt", {30'd0, head_tgt}, {30'd0, mq_tgt[0]});
                chk("R2 head deferred", {31'd0, head_deferred}, {31'd0, mq_dfr[0]});
            end
        end
        // advance the model to the state after the coming rising edge
        if (r) begin
            model_reset();
        end else begin
            acc = v && !st_e;
            pp  = rdy && (mq_n > 0);
            for (int i = 0; i < 2; i++) o_st[i] = ms_st[i];
            if (pp && mq_dfr[0])
                for (int i = 0; i < 2; i++)
                    if (o_st[i] == 1 && ms_tgt[i] == mq_tgt[0]) ms_st[i] = 2;
            if (dn)
                for (int i = 0; i < 2; i++)
                    if (o_st[i] == 2 && ms_tgt[i] == dt) ms_st[i] = 0;
            if (acc && d) begin
                if (o_st[0] == 0) begin ms_st[0] = 1; ms_tgt[0] = t; end
                else begin ms_st[1] = 1; ms_tgt[1] = t; end
            end
            if (pp) begin
                for (int i = 0; i < 15; i++) begin
                    mq_line[i] = mq_line[i+1]; mq_wr[i] = mq_wr[i+1];
                    mq_tgt[i] = mq_tgt[i+1]; mq_dfr[i] = mq_dfr[i+1];
                end
                mq_n--;
            end
            if (acc) begin
                mq_line[mq_n] = a[31:6]; mq_wr[mq_n] = w;
                mq_tgt[mq_n] = t; mq_dfr[mq_n] = d;
                mq_n++;
            end
        end
    endtask

    task automatic idle();
        cyc(0, 0, 32'd0, 0, 2'd0, 0, 0, 0, 2'd0);
    endtask

    task automatic do_reset();
        cyc(1, 0, 32'd0, 0, 2'd0, 0, 0, 0, 2'd0);
        cyc(1, 0, 32'd0, 0, 2'd0, 0, 0, 0, 2'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7177));
        model_reset();
        do_reset();

        // R1: reset state, deferred request offered
        cyc(0, 0, 32'h0, 0, 2'd2, 1, 0, 0, 2'd0);
        chk("R1 head_valid", {31'd0, head_valid}, 32'd0);
        chk("R1 q_count", {28'd0, q_count}, 32'd0);
        chk("R1 dfr_wait", {28'd0, dfr_wait}, 32'd0);
        chk("R1 stall", {31'd0, req_stall}, 32'd0);

        // R9: next-cycle visibility
        cyc(0, 1, 32'h1234_567F, 1, 2'd0, 0, 0, 0, 2'd0);
        idle();
        chk("R9 head_valid", {31'd0, head_valid}, 32'd1);
        chk("R9 q_count", {28'd0, q_count}, 32'd1);
        chk("R4 head_addr", head_addr, 32'h1234_5640);

        // R10: simultaneous push and pop
        cyc(0, 1, 32'hABCD_0011, 0, 2'd1, 0, 1, 0, 2'd0);
        idle();
        chk("R10 q_count", {28'd0, q_count}, 32'd1);
        chk("R10 head_addr", head_addr, 32'hABCD_0000);

        // R3: fill to twelve, then overflow attempt
        do_reset();
        for (int i = 0; i < 12; i++)
            cyc(0, 1, 32'h1000_0000 + i * 32'h47, i[0], 2'(i), 0, 0, 0, 2'd0);
        cyc(0, 1, 32'hFFFF_FFFF, 1, 2'd3, 0, 0, 0, 2'd0);
        chk("R3 full count", {28'd0, q_count}, 32'd12);
        chk("R3 full stall", {31'd0, req_stall}, 32'd1);
        for (int i = 0; i < 14; i++) cyc(0, 0, 32'd0, 0, 2'd0, 0, 1, 0, 2'd0);
        chk("R2 drained", {31'd0, head_valid}, 32'd0);

        // R5 / R6 / R7 / R8: defer slots
        do_reset();
        cyc(0, 1, 32'h2000_0000, 0, 2'd2, 1, 0, 0, 2'd0);
        cyc(0, 1, 32'h2000_0040, 0, 2'd2, 1, 0, 0, 2'd0);
        chk("R6 same tgt deferred", {31'd0, req_stall}, 32'd1);
        cyc(0, 1, 32'h2000_0080, 1, 2'd2, 0, 0, 0, 2'd0);
        chk("R6 same tgt plain", {31'd0, req_stall}, 32'd0);
        cyc(0, 1, 32'h2000_00C0, 0, 2'd1, 1, 0, 0, 2'd0);
        cyc(0, 1, 32'h2000_0100, 0, 2'd3, 1, 0, 0, 2'd0);
        chk("R5 both slots busy", {31'd0, req_stall}, 32'd1);
        cyc(0, 0, 32'd0, 0, 2'd0, 0, 0, 1, 2'd2);
        idle();
        chk("R8 early done ignored", {28'd0, dfr_wait}, 32'd0);
        cyc(0, 1, 32'h2000_0140, 0, 2'd2, 1, 0, 0, 2'd0);
        chk("R8 slot still held", {31'd0, req_stall}, 32'd1);
        cyc(0, 0, 32'd0, 0, 2'd0, 0, 1, 0, 2'd0);
        idle();
        chk("R7 wait after retire", {28'd0, dfr_wait}, 32'h4);
        cyc(0, 0, 32'd0, 0, 2'd0, 0, 0, 1, 2'd0);
        idle();
        chk("R8 other tgt done ignored", {28'd0, dfr_wait}, 32'h4);
        cyc(0, 0, 32'd0, 0, 2'd0, 0, 0, 1, 2'd2);
        idle();
        chk("R8 freed", {28'd0, dfr_wait}, 32'd0);
        cyc(0, 1, 32'h2000_0180, 0, 2'd2, 1, 0, 0, 2'd0);
        chk("R8 reaccept", {31'd0, req_stall}, 32'd0);

        // R11: reset mid-operation
        cyc(1, 0, 32'd0, 0, 2'd0, 0, 0, 0, 2'd0);
        idle();
        chk("R11 q_count", {28'd0, q_count}, 32'd0);
        chk("R11 head_valid", {31'd0, head_valid}, 32'd0);
        cyc(0, 1, 32'h3000_0000, 0, 2'd1, 1, 0, 0, 2'd0);
        chk("R11 slots cleared", {31'd0, req_stall}, 32'd0);

        // constrained random traffic
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            cyc(0, ($urandom % 4) != 0, $urandom, $urandom % 2, 2'($urandom % 4),
                ($urandom % 3) == 0, ($urandom % 3) == 0 || (k % 200 > 150),
                ($urandom % 3) == 0, 2'($urandom % 4));
        end

        fin = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule